// File: doc/BRIEF.md
# External Memory Space Select

This block generates the active-low data-space select for a small 8-bit microcontroller core. The core reaches two separate external spaces of up to 64 KB each, program and data. The select line is the only thing that tells them apart. On every cycle the core's sequencer reports what kind of access it is making. The block turns that report into the select level. Stack-class accesses count as data-space accesses only when the stack has been configured to live off-chip.

Two write-only configuration registers sit in the register file. The port-3 mode register, at address F7h, chooses what drives port-3 pin 4 through its bits 4:3. With 00 the pin carries bit 4 of the port output latch. With 01 or 10 it carries the select. With 11 the pin is handed to the handshake logic. The port 0–1 mode register, at address F8h, holds the stack-location flag in bit 2, where 0 means external and 1 means internal. Neither register can be read back.

Top module: `xspace_sel`

## Requirements
- R1: After reset the port-3 pin mode is 00 and the stack location is internal. The pad therefore follows the latch bit, the handshake flag is 0, and a stack access leaves the select high.
- R2: With access code 01 (program fetch), `sel_n` is 1.
- R3: With access code 10 (external data transfer), `sel_n` is 0.
- R4: With access code 11 (stack operation), `sel_n` is 0 when the stack flag (F8h bit 2) is 0 (external), and 1 when that flag is 1 (internal).
- R5: With access code 00 (idle), `sel_n` is 1.
- R6: When F7h bits 4:3 are 01 or 10, `p34_pad` equals `sel_n`.
- R7: When F7h bits 4:3 are 00, `p34_pad` equals `p3_latch_b4` and `hs_mode` is 0. When they are 11, `p34_pad` equals `hs_p34` and `hs_mode` is 1.
- R8: A register takes a new value on the clock edge that ends a cycle in which `wr_en` is 1 and `wr_addr` names that register. A write with `wr_en` 0, or to any other address, changes neither register.
- R9: When a write to F8h and a stack access fall in the same cycle, that access uses the stack location held before the write. The new location applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register-file write strobe |
| wr_addr | input | 8 | Register-file write address |
| wr_data | input | 8 | Register-file write data |
| acc_kind | input | 2 | Access code: 00 idle, 01 fetch, 10 external data, 11 stack |
| p3_latch_b4 | input | 1 | Bit 4 of the port-3 output latch |
| hs_p34 | input | 1 | Value the handshake logic drives onto pin 4 |
| sel_n | output | 1 | Data-space select, active low |
| p34_pad | output | 1 | Value driven onto port-3 pin 4 |
| hs_mode | output | 1 | Pin 4 is owned by the handshake logic |

## Verification
A configuration write and an access that depends on it can land in the same cycle. The clearest case is a write to F8h that flips the stack location while the sequencer reports a stack operation. The same risk exists for a write to F7h issued while the select is active. The bench issues such paired cycles in both directions, external to internal and back. It expects the select and the pad in that cycle to follow the old setting and the next cycle to follow the new one. Because the select is combinational, any early forwarding of the written value shows up as a wrong level inside the write cycle itself.

// File: rtl/xspace_pkg.sv
package xspace_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_FETCH = 2'b01,
        ACC_XDATA = 2'b10,
        ACC_STACK = 2'b11
    } acc_kind_t;

    typedef enum logic [1:0] {
        PIN_LATCH = 2'b00,
        PIN_SEL_A = 2'b01,
        PIN_SEL_B = 2'b10,
        PIN_HSHK  = 2'b11
    } pin_mode_t;

    typedef struct packed {
        pin_mode_t pin_mode;
        logic      stack_ext;
    } xcfg_t;

    localparam xcfg_t CFG_RESET = '{pin_mode: PIN_LATCH, stack_ext: 1'b0};

    // Active-low select level for one access.
    function automatic logic sel_level(input acc_kind_t kind, input logic stack_ext);
        case (kind)
            ACC_XDATA: return 1'b0;
            ACC_STACK: return !stack_ext;
            default:   return 1'b1;
        endcase
    endfunction

    function automatic logic mode_carries_sel(input pin_mode_t m);
        return (m == PIN_SEL_A) || (m == PIN_SEL_B);
    endfunction

endpackage

// File: rtl/xspace_cfg.sv
module xspace_cfg
    import xspace_pkg::*;
#(
    parameter int                AW       = ADDR_W,
    parameter int                DW       = DATA_W,
    parameter logic [ADDR_W-1:0] PIN_ADDR = 8'hF7,
    parameter logic [ADDR_W-1:0] STK_ADDR = 8'hF8,
    parameter int                PIN_LSB  = 3,
    parameter int                STK_BIT  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output xcfg_t         cfg
);
    localparam int PIN_MSB = PIN_LSB + 1;

    logic hit_pin;
    logic hit_stk;

    assign hit_pin = wr_en && (wr_addr == AW'(PIN_ADDR));
    assign hit_stk = wr_en && (wr_addr == AW'(STK_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else begin
            if (hit_pin) cfg.pin_mode  <= pin_mode_t'(wr_data[PIN_MSB:PIN_LSB]);
            // stored as "external" so the flag's 0 = external sense is inverted once here
            if (hit_stk) cfg.stack_ext <= !wr_data[STK_BIT];
        end
    end
endmodule

// File: rtl/xspace_selgen.sv
module xspace_selgen
    import xspace_pkg::*;
(
    input  acc_kind_t kind,
    input  logic      stack_ext,
    output logic      sel_n
);
    always_comb begin
        sel_n = sel_level(kind, stack_ext);
    end
endmodule

// File: rtl/xspace_pinmux.sv
module xspace_pinmux
    import xspace_pkg::*;
(
    input  pin_mode_t mode,
    input  logic      sel_n,
    input  logic      latch_b4,
    input  logic      hs_drive,
    output logic      pad,
    output logic      hs_own
);
    always_comb begin
        hs_own = 1'b0;
        unique case (mode)
            PIN_LATCH:            pad = latch_b4;
            PIN_SEL_A, PIN_SEL_B: pad = sel_n;
            PIN_HSHK: begin
                pad    = hs_drive;
                hs_own = 1'b1;
            end
            default:              pad = latch_b4;
        endcase
    end
endmodule

// File: rtl/xspace_sel.sv
module xspace_sel
    import xspace_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        acc_kind,
    input  logic              p3_latch_b4,
    input  logic              hs_p34,
    output logic              sel_n,
    output logic              p34_pad,
    output logic              hs_mode
);
    xcfg_t     cfg;
    acc_kind_t kind;

    assign kind = acc_kind_t'(acc_kind);

    xspace_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    xspace_selgen u_sel (
        .kind      (kind),
        .stack_ext (cfg.stack_ext),
        .sel_n     (sel_n)
    );

    xspace_pinmux u_mux (
        .mode     (cfg.pin_mode),
        .sel_n    (sel_n),
        .latch_b4 (p3_latch_b4),
        .hs_drive (hs_p34),
        .pad      (p34_pad),
        .hs_own   (hs_mode)
    );
endmodule

// File: rtl/xspace_sel_chk.sv
module xspace_sel_chk
    import xspace_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        acc_kind,
    input logic              p3_latch_b4,
    input logic              hs_p34,
    input logic              sel_n,
    input logic              p34_pad,
    input logic              hs_mode,
    input xcfg_t             cfg
);
    p_fetch_high_r2: assert property (@(posedge clk) disable iff (rst)
        acc_kind == 2'b01 |-> sel_n);

    p_xdata_low_r3: assert property (@(posedge clk) disable iff (rst)
        acc_kind == 2'b10 |-> !sel_n);

    p_stack_follow_r4: assert property (@(posedge clk) disable iff (rst)
        acc_kind == 2'b11 |-> sel_n == !cfg.stack_ext);

    p_idle_high_r5: assert property (@(posedge clk) disable iff (rst)
        acc_kind == 2'b00 |-> sel_n);

    p_pad_is_sel_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg.pin_mode == PIN_SEL_A || cfg.pin_mode == PIN_SEL_B) |-> p34_pad == sel_n);

    p_pad_hshk_r7: assert property (@(posedge clk) disable iff (rst)
        hs_mode |-> p34_pad == hs_p34);

    p_stk_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 8'hF8) |=> cfg.stack_ext == !$past(wr_data[2]));

    p_no_write_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_addr == 8'hF7 || wr_addr == 8'hF8)) |=> $stable(cfg));
endmodule

bind xspace_sel xspace_sel_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .acc_kind    (acc_kind),
    .p3_latch_b4 (p3_latch_b4),
    .hs_p34      (hs_p34),
    .sel_n       (sel_n),
    .p34_pad     (p34_pad),
    .hs_mode     (hs_mode),
    .cfg         (cfg)
);

// File: tb/sim_xspace_sel.sv
`timescale 1ns/1ps
module sim_xspace_sel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] acc_kind = 2'b00;
    logic       p3_latch_b4 = 1'b0;
    logic       hs_p34 = 1'b0;
    logic       sel_n;
    logic       p34_pad;
    logic       hs_mode;

    always #5 clk = ~clk;

    xspace_sel u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .acc_kind(acc_kind), .p3_latch_b4(p3_latch_b4), .hs_p34(hs_p34),
        .sel_n(sel_n), .p34_pad(p34_pad), .hs_mode(hs_mode)
    );

    typedef struct {
        logic  sel;
        logic  pad;
        logic  hs;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;

    // bench model of the configuration
    logic [1:0] m_mode  = 2'b00;
    logic       m_stk_f = 1'b1;   // flag as written: 0 external, 1 internal

    task automatic step(input logic we, input logic [7:0] wa, input logic [7:0] wd,
                        input logic [1:0] acc, input logic lat, input logic hs,
                        input string req);
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        acc_kind = acc; p3_latch_b4 = lat; hs_p34 = hs;
        case (acc)
            2'b10:   e.sel = 1'b0;
            2'b11:   e.sel = m_stk_f;
            default: e.sel = 1'b1;
        endcase
        case (m_mode)
            2'b00:   e.pad = lat;
            2'b11:   e.pad = hs;
            default: e.pad = e.sel;
        endcase
        e.hs  = (m_mode == 2'b11);
        e.req = req;
        exp_q.push_back(e);
        if (we && wa == 8'hF7) m_mode  = wd[4:3];
        if (we && wa == 8'hF8) m_stk_f = wd[2];
    endtask

    // monitor: compares mid-cycle, after the driver's inputs have settled
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() != 0) begin
                e = exp_q.pop_front();
                checks++;
                if (sel_n !== e.sel || p34_pad !== e.pad || hs_mode !== e.hs) begin
                    failures++;
                    $display("FAIL %s: sel_n/pad/hs actual=%b%b%b expected=%b%b%b",
                             e.req, sel_n, p34_pad, hs_mode, e.sel, e.pad, e.hs);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state: pad follows latch, stack internal
        step(0, 8'h00, 8'h00, 2'b11, 1'b1, 1'b0, "R1 stack after reset");
        step(0, 8'h00, 8'h00, 2'b01, 1'b0, 1'b1, "R1 latch after reset");
        // R2 R3 R5 under latch mode
        step(0, 8'h00, 8'h00, 2'b01, 1'b1, 1'b0, "R2 fetch");
        step(0, 8'h00, 8'h00, 2'b10, 1'b0, 1'b0, "R3 xdata");
        step(0, 8'h00, 8'h00, 2'b00, 1'b1, 1'b0, "R5 idle");
        // R6 enable select on pin with code 10
        step(1, 8'hF7, 8'h10, 2'b00, 1'b0, 1'b0, "R8 write F7 10");
        step(0, 8'h00, 8'h00, 2'b10, 1'b1, 1'b1, "R6 pad low xdata");
        step(0, 8'h00, 8'h00, 2'b01, 1'b0, 1'b0, "R6 pad high fetch");
        // R4 stack external
        step(1, 8'hF8, 8'h00, 2'b00, 1'b0, 1'b0, "R8 write F8 ext");
        step(0, 8'h00, 8'h00, 2'b11, 1'b1, 1'b0, "R4 stack external");
        // R9 same-cycle write to internal with stack access, then back
        step(1, 8'hF8, 8'h04, 2'b11, 1'b0, 1'b0, "R9 old ext in write cycle");
        step(0, 8'h00, 8'h00, 2'b11, 1'b0, 1'b0, "R9 new internal next cycle");
        step(1, 8'hF8, 8'h00, 2'b11, 1'b1, 1'b0, "R9 old int in write cycle");
        step(0, 8'h00, 8'h00, 2'b11, 1'b1, 1'b0, "R4 stack ext again");
        // R8 ignored writes: wrong address and no strobe
        step(1, 8'hF9, 8'h04, 2'b00, 1'b0, 1'b0, "R8 other addr");
        step(0, 8'hF8, 8'h04, 2'b00, 1'b0, 1'b0, "R8 no strobe");
        step(0, 8'h00, 8'h00, 2'b11, 1'b0, 1'b0, "R8 stack still ext");
        // R6 mode 01
        step(1, 8'hF7, 8'h08, 2'b00, 1'b0, 1'b0, "R8 write F7 01");
        step(0, 8'h00, 8'h00, 2'b10, 1'b1, 1'b1, "R6 mode01 xdata");
        // R7 handshake mode; write in same cycle as xdata
        step(1, 8'hF7, 8'h18, 2'b10, 1'b1, 1'b1, "R9 pin mode old in write cycle");
        step(0, 8'h00, 8'h00, 2'b10, 1'b0, 1'b1, "R7 handshake high");
        step(0, 8'h00, 8'h00, 2'b01, 1'b1, 1'b0, "R7 handshake low");
        // R7 back to latch mode, other bits set
        step(1, 8'hF7, 8'hE7, 2'b00, 1'b0, 1'b0, "R8 write F7 00");
        step(0, 8'h00, 8'h00, 2'b10, 1'b1, 1'b0, "R7 latch high");
        step(0, 8'h00, 8'h00, 2'b10, 1'b0, 1'b1, "R7 latch low");
        // R1 reset again restores defaults
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_mode = 2'b00;
        m_stk_f = 1'b1;
        step(0, 8'h00, 8'h00, 2'b11, 1'b0, 1'b1, "R1 re-reset");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule